// File: doc/BRIEF.md
# Reservation-Table Issue Collision Checker

This block decides, cycle by cycle, whether an instruction may start without colliding with the instructions already in flight. Each instruction class has a small table of rows and columns: the rows are resources and the columns are clock cycles after issue. A set bit means the resource is busy in that cycle. There are two pipelines, integer and load/store. Each has the four stages fetch, decode, execute and write-back. There are also shared register-access rows, so that register ports can be kept in program order in the same way as stages.

The checker keeps a map of future resource use and lays the requesting class's table over it. Where no set bits meet, it grants issue and merges the table into the map. Where any bits meet, it reports a stall and leaves the map alone, so work that entered earlier keeps its resources. The map moves one column closer to the present every clock. The checker also gives the self-collision set of the selected class: each issue distance K from 1 to 7 at which the class's table, shifted by K against itself, lands on a busy cell. The class tables can be rewritten through a configuration port, but only while nothing is in flight.

Top module: `rct_collision_checker`

## Requirements
- R1: Out of reset, the map is empty. Every class holds the default table, in which stage row s (fetch=0, decode=1, execute=2, write-back=3) is busy only in column s and the register rows are clear. With that table, forbid is zero and a request in every cycle is granted.
- R2: forbid bit K-1 (K=1..7) is 1 exactly when some row of the table of the class on issueClass has bits set in both column c and column c+K. It is combinational and depends on neither the pipeline select nor the map.
- R3: A request is granted in the same cycle when no set bit of the candidate table meets a busy cell of the map. Otherwise stall is raised in that cycle.
- R4: A granted table is merged into the map at the next edge. A stalled request leaves the map unchanged.
- R5: At each edge the map moves by one column. A cell reserved c cycles ahead blocks only a request made exactly c cycles later. Nothing is held beyond 8 columns.
- R6: Table rows 0..3 are applied to the stages of the pipeline on issuePipe (0 = integer, 1 = load/store). Stage use on one pipeline never blocks the other.
- R7: Table rows 4 and 5 are register-access rows that both pipelines share. They collide across pipelines.
- R8: A configuration write of cfgData into row cfgRow of class cfgClass (bit c = column c) takes effect at the edge only when the map is empty and issueReq is low. Otherwise it is ignored.
- R9: A configuration write with cfgRow of 6 or 7 is ignored.
- R10: grant and stall are never both high. With a request exactly one of them is high, and with no request both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueReq | input | 1 | Issue request this cycle |
| issueClass | input | 2 | Class of the requesting instruction; also selects the class for forbid |
| issuePipe | input | 1 | Target pipeline, 0 integer, 1 load/store |
| cfgWe | input | 1 | Table write strobe |
| cfgClass | input | 2 | Class whose table is written |
| cfgRow | input | 3 | Table row written (0..5 valid) |
| cfgData | input | 8 | Row contents, bit c = busy c cycles after issue |
| grant | output | 1 | Request may issue this cycle |
| stall | output | 1 | Request collides and must wait |
| forbid | output | 7 | Bit K-1 set when issue distance K collides with itself |

## Verification
The hardest case to reach is a collision that comes only through the shared register rows. It needs two different pipelines, a class whose register use spans several columns, and an exact gap between issues. The stimulus loads a class whose register row is busy in columns 1 and 5. It issues that class on the integer pipe and then on the load/store pipe exactly four cycles later. A reference map in the bench predicts grant and stall on every clock, also through a long stretch of random requests. The ignored write cases are set up on purpose: a write while reservations are still draining, a write in the same cycle as a request, and a write to an invalid row. Each is then followed by a read of forbid.

// File: rtl/rct_pkg.sv
package rct_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgWrite;   // commit a table row this edge
    logic occMerge;   // merge the candidate into the occupancy map
  } rctStrobes_t;

  typedef enum logic {
    PIPE_INT = 1'b0,
    PIPE_LS  = 1'b1
  } rctPipe_e;

endpackage

// File: rtl/rct_latency.sv
module rct_latency #(
  parameter int ROWS  = 6,
  parameter int DEPTH = 8
) (
  input  logic [ROWS-1:0][DEPTH-1:0] tblIn,
  output logic [DEPTH-2:0]           forbid
);

  for (genvar k = 1; k < DEPTH; k++) begin : g_lat
    logic [ROWS-1:0] rowHit;
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign rowHit[r] = |(tblIn[r] & (tblIn[r] >> k));
    end
    assign forbid[k-1] = |rowHit;
  end

endmodule

// File: rtl/rct_control.sv
module rct_control
  import rct_pkg::*;
#(
  parameter int LROWS = 6,
  parameter int ROW_W = 3
) (
  input  logic             issueReq,
  input  logic             conflict,
  input  logic             occEmpty,
  input  logic             cfgWe,
  input  logic [ROW_W-1:0] cfgRow,
  output rctStrobes_t      strobes,
  output logic             grant,
  output logic             stall
);

  logic rowValid;

  always_comb begin
    rowValid         = int'(cfgRow) < LROWS;
    grant            = issueReq && !conflict;
    stall            = issueReq && conflict;
    strobes.occMerge = grant;
    strobes.cfgWrite = cfgWe && rowValid && occEmpty && !issueReq;
  end

endmodule

// File: rtl/rct_datapath.sv
module rct_datapath
  import rct_pkg::*;
#(
  parameter int NUM_CLASSES  = 4,
  parameter int DEPTH        = 8,
  parameter int NUM_STAGES   = 4,
  parameter int NUM_PIPES    = 2,
  parameter int NUM_REG_ROWS = 2,
  parameter int CLS_W        = 2,
  parameter int PIPE_W       = 1,
  parameter int LROWS        = 6,
  parameter int ROW_W        = 3,
  parameter int GROWS        = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  rctStrobes_t       strobes,
  input  logic [CLS_W-1:0]  issueClass,
  input  logic [PIPE_W-1:0] issuePipe,
  input  logic [CLS_W-1:0]  cfgClass,
  input  logic [ROW_W-1:0]  cfgRow,
  input  logic [DEPTH-1:0]  cfgData,
  output logic              conflict,
  output logic              occEmpty,
  output logic [DEPTH-2:0]  forbid
);

  logic [NUM_CLASSES-1:0][LROWS-1:0][DEPTH-1:0] tbl;
  logic [LROWS-1:0][DEPTH-1:0]                  selTbl;
  logic [GROWS-1:0][DEPTH-1:0]                  occ;
  logic [GROWS-1:0][DEPTH-1:0]                  cand;

  // Class table store; reset gives each stage a single cycle in order
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CLASSES; c++) begin
        for (int r = 0; r < LROWS; r++) begin
          tbl[c][r] <= (r < NUM_STAGES) ? (DEPTH'(1) << r) : '0;
        end
      end
    end else if (strobes.cfgWrite) begin
      tbl[cfgClass][cfgRow] <= cfgData;
    end
  end

  assign selTbl = tbl[issueClass];

  // Expand the local table onto global resource rows
  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      assign cand[p*NUM_STAGES+s] = (issuePipe == PIPE_W'(p)) ? selTbl[s] : '0;
    end
  end
  for (genvar j = 0; j < NUM_REG_ROWS; j++) begin : g_reg
    assign cand[NUM_PIPES*NUM_STAGES+j] = selTbl[NUM_STAGES+j];
  end

  assign conflict = |(occ & cand);
  assign occEmpty = ~|occ;

  // Occupancy map: column 0 is the current cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      for (int r = 0; r < GROWS; r++) begin
        occ[r] <= (occ[r] | (strobes.occMerge ? cand[r] : '0)) >> 1;
      end
    end
  end

  rct_latency #(
    .ROWS  (LROWS),
    .DEPTH (DEPTH)
  ) i_latency (
    .tblIn  (selTbl),
    .forbid (forbid)
  );

endmodule

// File: rtl/rct_collision_checker.sv
module rct_collision_checker
  import rct_pkg::*;
#(
  parameter int NUM_CLASSES  = 4,
  parameter int DEPTH        = 8,
  parameter int NUM_STAGES   = 4,
  parameter int NUM_PIPES    = 2,
  parameter int NUM_REG_ROWS = 2,
  localparam int CLS_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int PIPE_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1,
  localparam int LROWS  = NUM_STAGES + NUM_REG_ROWS,
  localparam int ROW_W  = $clog2(LROWS + 1),
  localparam int GROWS  = NUM_PIPES * NUM_STAGES + NUM_REG_ROWS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueReq,
  input  logic [CLS_W-1:0]  issueClass,
  input  logic [PIPE_W-1:0] issuePipe,
  input  logic              cfgWe,
  input  logic [CLS_W-1:0]  cfgClass,
  input  logic [ROW_W-1:0]  cfgRow,
  input  logic [DEPTH-1:0]  cfgData,
  output logic              grant,
  output logic              stall,
  output logic [DEPTH-2:0]  forbid
);

  rctStrobes_t strobes;
  logic        conflict;
  logic        occEmpty;

  rct_control #(
    .LROWS (LROWS),
    .ROW_W (ROW_W)
  ) i_control (
    .issueReq (issueReq),
    .conflict (conflict),
    .occEmpty (occEmpty),
    .cfgWe    (cfgWe),
    .cfgRow   (cfgRow),
    .strobes  (strobes),
    .grant    (grant),
    .stall    (stall)
  );

  rct_datapath #(
    .NUM_CLASSES  (NUM_CLASSES),
    .DEPTH        (DEPTH),
    .NUM_STAGES   (NUM_STAGES),
    .NUM_PIPES    (NUM_PIPES),
    .NUM_REG_ROWS (NUM_REG_ROWS),
    .CLS_W        (CLS_W),
    .PIPE_W       (PIPE_W),
    .LROWS        (LROWS),
    .ROW_W        (ROW_W),
    .GROWS        (GROWS)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .issueClass (issueClass),
    .issuePipe  (issuePipe),
    .cfgClass   (cfgClass),
    .cfgRow     (cfgRow),
    .cfgData    (cfgData),
    .conflict   (conflict),
    .occEmpty   (occEmpty),
    .forbid     (forbid)
  );

endmodule

// File: rtl/rct_collision_checker_sva.sv
module rct_collision_checker_sva #(
  parameter int CLS_W  = 2,
  parameter int PIPE_W = 1,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              issueReq,
  input logic [CLS_W-1:0]  issueClass,
  input logic [PIPE_W-1:0] issuePipe,
  input logic              cfgWe,
  input logic              grant,
  input logic              stall,
  input logic [DEPTH-2:0]  forbid
);

  // R10: a request yields exactly one outcome
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    issueReq |-> (grant ^ stall));

  // R10: no outcome without a request
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !issueReq |-> (!grant && !stall));

  // R3: same class on same pipe one cycle after a grant stalls when latency 1 is forbidden
  p_latency_one_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(grant) && issueReq && forbid[0] &&
     issueClass == $past(issueClass) && issuePipe == $past(issuePipe)) |-> stall);

  // R2: forbid only moves with the class selection or after a write strobe
  p_forbid_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfgWe) && $stable(issueClass)) |-> $stable(forbid));

  // R8: a write made together with a request has no effect
  p_write_with_req_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfgWe) && $past(issueReq) && $stable(issueClass)) |-> $stable(forbid));

endmodule

bind rct_collision_checker rct_collision_checker_sva #(
  .CLS_W  (CLS_W),
  .PIPE_W (PIPE_W),
  .DEPTH  (DEPTH)
) i_sva (
  .clk        (clk),
  .rst        (rst),
  .issueReq   (issueReq),
  .issueClass (issueClass),
  .issuePipe  (issuePipe),
  .cfgWe      (cfgWe),
  .grant      (grant),
  .stall      (stall),
  .forbid     (forbid)
);

// File: tb/test_rct_collision_checker.sv
`timescale 1ns/1ps
module test_rct_collision_checker;

  localparam int NC = 4;
  localparam int LR = 6;
  localparam int GR = 10;
  localparam int NS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issueReq = 1'b0;
  logic [1:0] issueClass = '0;
  logic       issuePipe = 1'b0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgClass = '0;
  logic [2:0] cfgRow = '0;
  logic [7:0] cfgData = '0;
  logic       grant, stall;
  logic [6:0] forbid;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  done = 0;

  bit [7:0] mTbl [NC][LR];
  bit [7:0] mOcc [GR];

  always #2 clk = ~clk;

  rct_collision_checker i_rct_collision_checker (
    .clk(clk), .rst(rst), .issueReq(issueReq), .issueClass(issueClass),
    .issuePipe(issuePipe), .cfgWe(cfgWe), .cfgClass(cfgClass), .cfgRow(cfgRow),
    .cfgData(cfgData), .grant(grant), .stall(stall), .forbid(forbid));

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit [7:0] candRow(input int cls, input int pipe, input int g);
    if (g < 8) return ((g / NS) == pipe) ? mTbl[cls][g % NS] : 8'h00;
    return mTbl[cls][NS + g - 8];
  endfunction

  function automatic bit [6:0] modelForbid(input int cls);
    bit [6:0] f = '0;
    for (int k = 1; k < 8; k++)
      for (int r = 0; r < LR; r++)
        for (int c = 0; c + k < 8; c++)
          if (mTbl[cls][r][c] && mTbl[cls][r][c+k]) f[k-1] = 1'b1;
    return f;
  endfunction

  task automatic step(input bit req, input int cls, input int pipe, input bit we,
                      input int wc, input int wr, input bit [7:0] wd, input string tag);
    bit conf;
    bit idle;
    @(negedge clk);
    issueReq = req; issueClass = 2'(cls); issuePipe = pipe[0];
    cfgWe = we; cfgClass = 2'(wc); cfgRow = 3'(wr); cfgData = wd;
    #1;
    conf = 1'b0;
    idle = !req;
    for (int g = 0; g < GR; g++) begin
      if ((mOcc[g] & candRow(cls, pipe, g)) != 0) conf = 1'b1;
      if (mOcc[g] != 0) idle = 1'b0;
    end
    check(tag, "grant", int'(grant), int'(req && !conf));
    check(tag, "stall", int'(stall), int'(req && conf));
    check("R2", "forbid", int'(forbid), int'(modelForbid(cls)));
    if (req && !conf)
      for (int g = 0; g < GR; g++) mOcc[g] |= candRow(cls, pipe, g);
    for (int g = 0; g < GR; g++) mOcc[g] = mOcc[g] >> 1;
    if (we && idle && wr < LR) mTbl[wc][wr] = wd;
  endtask

  task automatic idleFor(input int n, input int cls, input string tag);
    for (int i = 0; i < n; i++) step(0, cls, 0, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic writeRow(input int c, input int r, input bit [7:0] d);
    step(0, c, 0, 1, c, r, d, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog R10: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < LR; r++)
        mTbl[c][r] = (r < NS) ? 8'(1 << r) : 8'h00;
    for (int g = 0; g < GR; g++) mOcc[g] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state and default tables accept back-to-back issue
    #1;
    check("R1", "grant", int'(grant), 0);
    check("R1", "stall", int'(stall), 0);
    check("R1", "forbid", int'(forbid), 0);
    for (int i = 0; i < 4; i++) step(1, i, i % 2, 0, 0, 0, 8'h00, "R1");
    idleFor(8, 0, "R5");

    // R8: load tables while idle
    writeRow(0, 0, 8'h01); writeRow(0, 1, 8'h02); writeRow(0, 2, 8'h0C); writeRow(0, 3, 8'h10);
    writeRow(1, 0, 8'h01); writeRow(1, 1, 8'h02); writeRow(1, 2, 8'h04); writeRow(1, 3, 8'h08);
    writeRow(1, 4, 8'h08);
    writeRow(2, 0, 8'h01); writeRow(2, 1, 8'h02); writeRow(2, 2, 8'h04); writeRow(2, 3, 8'h08);
    writeRow(2, 5, 8'h22);
    writeRow(3, 0, 8'h05); writeRow(3, 1, 8'h08); writeRow(3, 2, 8'h10); writeRow(3, 3, 8'h20);

    // R2: forbidden sets per class
    for (int c = 0; c < NC; c++) step(0, c, 0, 0, 0, 0, 8'h00, "R2");

    // R3 / R4: class 0 forbids distance 1
    step(1, 0, 0, 0, 0, 0, 8'h00, "R3");
    step(1, 0, 0, 0, 0, 0, 8'h00, "R4");
    step(1, 0, 0, 0, 0, 0, 8'h00, "R3");
    idleFor(8, 0, "R5");

    // R6: other pipeline unaffected by stage use
    step(1, 0, 0, 0, 0, 0, 8'h00, "R6");
    step(1, 0, 1, 0, 0, 0, 8'h00, "R6");
    idleFor(8, 0, "R5");

    // R7: shared register row collides across pipelines at distance 4
    step(1, 2, 0, 0, 0, 0, 8'h00, "R7");
    idleFor(3, 2, "R5");
    step(1, 2, 1, 0, 0, 0, 8'h00, "R7");
    step(1, 2, 1, 0, 0, 0, 8'h00, "R7");
    idleFor(8, 2, "R5");

    // R5: class 3 forbids distance 2, allows 1 and 3
    step(1, 3, 0, 0, 0, 0, 8'h00, "R5");
    step(0, 3, 0, 0, 0, 0, 8'h00, "R5");
    step(1, 3, 0, 0, 0, 0, 8'h00, "R5");
    step(1, 3, 0, 0, 0, 0, 8'h00, "R5");
    idleFor(8, 3, "R5");

    // R8: write while map busy is ignored, write with request ignored
    step(1, 0, 0, 0, 0, 0, 8'h00, "R8");
    step(0, 0, 0, 1, 0, 2, 8'h04, "R8");
    step(0, 0, 0, 0, 0, 0, 8'h00, "R8");
    idleFor(8, 0, "R8");
    step(1, 1, 0, 1, 0, 2, 8'h04, "R8");
    idleFor(8, 0, "R8");

    // R9: rows beyond the table are ignored
    step(0, 0, 0, 1, 0, 6, 8'hFF, "R9");
    step(0, 0, 0, 1, 0, 7, 8'hFF, "R9");
    step(0, 0, 0, 0, 0, 0, 8'h00, "R9");

    // R10: random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 60, $urandom_range(0, 3), $urandom_range(0, 1), r >= 92,
           $urandom_range(0, 3), $urandom_range(0, 7), 8'($urandom_range(0, 255)), "R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule